// File: doc/BRIEF.md
# Interrupt Redirection Unit

The unit turns a bank of 24 external interrupt lines into interrupt messages. Each line owns a 64-bit routing entry. The entry holds the vector, the delivery mode, the destination mode, the polarity, the trigger mode, a mask bit and an 8-bit destination. Software never addresses an entry directly. It first writes a select value at offset 0x00 and then reads or writes one 32-bit half of the selected register at offset 0x10.

A line set to level mode is pending while its input is high. A line set to edge mode latches a rising edge and stays pending until a message for that line is accepted. A single output port carries the messages under a valid/ready handshake. Pending, unmasked lines are served one per accepted cycle. A scan pointer walks upward from the line after the one served last and wraps at the top, so a level line that stays high cannot starve the lines above it.

Top module: `irq_redirect_unit`

## Requirements
- R1: After reset every entry reads 0x00010000 in its low half and 0 in its high half, the unit ID and the select register are 0, the scan pointer is 0, and no message is offered.
- R2: A write at offset 0x00 loads the 8-bit select from write-data bits [7:0]. Offset 0x00 reads the select zero-extended, and offset 0x10 reads the register the select names. Every other offset reads 0 and ignores writes. Register writes take effect at the next clock edge, and read data is combinational.
- R3: Select 0x00 holds the unit ID in bits [31:24]. Its other bits read 0 and are not stored.
- R4: Select 0x01 is read-only and reads 0x00170011: version 0x11 in [7:0] and the highest line index, 23, in [23:16].
- R5: Select 0x10+2n reaches the low 32 bits of entry n, and select 0x11+2n reaches its high 32 bits. A write replaces all 32 bits of that half and leaves the other half unchanged.
- R6: The selects 0x02–0x0F and 0x40–0xFF read 0, and writes to them change nothing.
- R7: A line whose entry bit 15 is 1 (level mode) has a pending state equal to its input sampled at the previous clock edge.
- R8: For a line whose bit 15 is 0 (edge mode), a 0-to-1 change of the input between two clock edges sets pending. Pending stays set until a message for that line is accepted, and the accept clears it unless a new rising edge arrives in the same cycle.
- R9: A line whose entry bit 16 is 1 is masked and offers no message. An edge pending on a masked line is kept and is offered once the line is unmasked.
- R10: The message carries the served line's entry fields: vector [7:0], delivery mode [10:8], destination mode bit 11, polarity bit 13, trigger mode bit 15 and destination [63:56]. The served line index is also output.
- R11: Valid is high exactly when some line is pending and unmasked. The line served is the first eligible one found at or above the scan pointer, wrapping past 23 to 0. After an accept the pointer moves to the served index plus one, modulo 24.
- R12: While ready is low nothing is accepted: edge pending bits and the scan pointer hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset (0x00 select, 0x10 window) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_pins_i | input | 24 | External interrupt lines |
| msg_valid_o | output | 1 | A message is offered |
| msg_ready_i | input | 1 | Consumer accepts the offered message |
| msg_pin_o | output | 5 | Line index of the offered message |
| msg_vector_o | output | 8 | Vector field |
| msg_deliv_o | output | 3 | Delivery mode field |
| msg_dest_mode_o | output | 1 | Destination mode field |
| msg_polarity_o | output | 1 | Polarity field |
| msg_trigger_o | output | 1 | Trigger mode field |
| msg_dest_o | output | 8 | Destination byte |

## Verification
Each line is driven with single pulses, sustained highs and simultaneous rises on several lines. Single pulses separate edge latching from level following. Sustained highs show whether a level line is re-served while its neighbours still get turns. Simultaneous rises show the order the scan pointer produces and the point where it wraps. Ready is held low, toggled and left high to show that an unaccepted message disturbs no state. Masks are changed while edges are pending, and entry halves are rewritten under traffic. Every read path and every routed field is compared against a behavioural model on every cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned ENTRY_W    = 64;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned SEL_W      = 8;

  localparam logic [ADDR_W-1:0] OFF_SELECT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WINDOW = 8'h10;

  localparam logic [SEL_W-1:0] SEL_ID      = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VERSION = 8'h01;
  localparam int unsigned      SEL_TBL_BASE = 16;

  localparam logic [7:0] VERSION_CODE = 8'h11;

  // entry field positions
  localparam int unsigned F_VEC_LSB   = 0;
  localparam int unsigned F_DLV_LSB   = 8;
  localparam int unsigned F_DMODE     = 11;
  localparam int unsigned F_POL       = 13;
  localparam int unsigned F_TRIG      = 15;
  localparam int unsigned F_MASK      = 16;
  localparam int unsigned F_DEST_LSB  = 56;

  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  output logic [NUM_PINS-1:0][ENTRY_W-1:0]  entries_o
);
  localparam int unsigned TBL_END = SEL_TBL_BASE + 2 * NUM_PINS;
  localparam logic [REG_W-1:0] VERSION_WORD =
      {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

  logic [SEL_W-1:0] sel_q;
  logic [7:0]       id_q;
  logic             win_wr;
  logic             sel_wr;
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entry_q;

  assign sel_wr = wr_i && (addr_i == OFF_SELECT);
  assign win_wr = wr_i && (addr_i == OFF_WINDOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata_i[SEL_W-1:0];
      if (win_wr && sel_q == SEL_ID) id_q <= wdata_i[31:24];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_entry
    localparam logic [SEL_W-1:0] SEL_LO = SEL_W'(SEL_TBL_BASE + 2 * i);
    localparam logic [SEL_W-1:0] SEL_HI = SEL_W'(SEL_TBL_BASE + 2 * i + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[i] <= ENTRY_RESET;
      end else if (win_wr) begin
        if (sel_q == SEL_LO) entry_q[i][31:0]  <= wdata_i;
        if (sel_q == SEL_HI) entry_q[i][63:32] <= wdata_i;
      end
    end

    // R5: low-half write keeps the high half
    a_r5_half_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_wr && sel_q == SEL_LO) |=>
        (entry_q[i][63:32] == $past(entry_q[i][63:32]) &&
         entry_q[i][31:0]  == $past(wdata_i)));
  end

  assign entries_o = entry_q;

  logic [REG_W-1:0] win_data;
  always_comb begin
    int tidx;
    tidx     = (int'(sel_q) - SEL_TBL_BASE) >>> 1;
    win_data = '0;
    if (sel_q == SEL_ID) begin
      win_data = {id_q, 24'h0};
    end else if (sel_q == SEL_VERSION) begin
      win_data = VERSION_WORD;
    end else if (int'(sel_q) >= SEL_TBL_BASE && int'(sel_q) < TBL_END) begin
      win_data = sel_q[0] ? entry_q[tidx][63:32] : entry_q[tidx][31:0];
    end
  end

  always_comb begin
    case (addr_i)
      OFF_SELECT: rdata_o = {{(REG_W-SEL_W){1'b0}}, sel_q};
      OFF_WINDOW: rdata_o = win_data;
      default:    rdata_o = '0;
    endcase
  end

  // R2: select write lands next cycle
  a_r2_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> (sel_q == $past(wdata_i[SEL_W-1:0])));

  // R3: id only changes through a window write at select 0
  a_r3_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_wr && sel_q == SEL_ID) |=> $stable(id_q));
endmodule

// File: rtl/irq_pin_pending.sv
module irq_pin_pending #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] prev_q, pend_q, pend_d, rise;
  logic                past_ok_q;

  assign rise   = pins_i & ~prev_q;
  // level lines mirror the input; edge lines latch rises, clear on accept
  assign pend_d = (level_i & pins_i) |
                  (~level_i & ((pend_q & ~clr_i) | rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      pend_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      prev_q    <= pins_i;
      pend_q    <= pend_d;
      past_ok_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R7: level lines follow the previous-cycle input
  a_r7_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((pend_q & $past(level_i)) == ($past(pins_i) & $past(level_i))));

  // R8: an edge pending without a clear survives the edge
  a_r8_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~level_i & ~clr_i)) ==
              $past(pend_q & ~level_i & ~clr_i)));
endmodule

// File: rtl/irq_msg_sched.sv
module irq_msg_sched #(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PW = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [PW-1:0]       idx_o,
  output logic [NUM_PINS-1:0] clr_o
);
  logic [PW-1:0]       ptr_q, ptr_d, pick;
  logic [NUM_PINS-1:0] elig, grant;
  logic                hit, accept;

  assign elig = pend_i & ~mask_i;

  // descending loop: the smallest offset from the pointer wins
  always_comb begin
    int p;
    hit  = 1'b0;
    pick = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      p = int'(ptr_q) + k;
      if (p >= int'(NUM_PINS)) p = p - int'(NUM_PINS);
      if (elig[p]) begin
        hit  = 1'b1;
        pick = PW'(p);
      end
    end
  end

  assign accept = hit && ready_i;

  always_comb begin
    grant = '0;
    if (hit) grant[pick] = 1'b1;
  end

  assign clr_o = accept ? grant : '0;

  always_comb begin
    ptr_d = ptr_q;
    if (accept) ptr_d = (int'(pick) == int'(NUM_PINS) - 1) ? '0 : pick + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign valid_o = hit;
  assign idx_o   = pick;

  // R11: at most one line served, pointer in range
  a_r11_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  a_r11_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < int'(NUM_PINS));
  // R12: no accept, no pointer move
  a_r12_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(ptr_q));
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  localparam int unsigned PW = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [NUM_PINS-1:0] irq_pins_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [PW-1:0]       msg_pin_o,
  output logic [7:0]          msg_vector_o,
  output logic [2:0]          msg_deliv_o,
  output logic                msg_dest_mode_o,
  output logic                msg_polarity_o,
  output logic                msg_trigger_o,
  output logic [7:0]          msg_dest_o
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entries;
  logic [NUM_PINS-1:0] level, mask, pend, clr;
  logic [ENTRY_W-1:0]  cur;

  irq_redir_regfile #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .entries_o (entries)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ctl
    assign level[i] = entries[i][F_TRIG];
    assign mask[i]  = entries[i][F_MASK];
  end

  irq_pin_pending #(.NUM_PINS(NUM_PINS)) i_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_i  (irq_pins_i),
    .level_i (level),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  irq_msg_sched #(.NUM_PINS(NUM_PINS)) i_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .mask_i  (mask),
    .ready_i (msg_ready_i),
    .valid_o (msg_valid_o),
    .idx_o   (msg_pin_o),
    .clr_o   (clr)
  );

  assign cur             = entries[msg_pin_o];
  assign msg_vector_o    = cur[F_VEC_LSB +: 8];
  assign msg_deliv_o     = cur[F_DLV_LSB +: 3];
  assign msg_dest_mode_o = cur[F_DMODE];
  assign msg_polarity_o  = cur[F_POL];
  assign msg_trigger_o   = cur[F_TRIG];
  assign msg_dest_o      = cur[F_DEST_LSB +: 8];

  // R9: an offered line is never masked and is pending
  a_r9_no_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (!mask[msg_pin_o] && pend[msg_pin_o]));
  // R11: valid whenever any unmasked line is pending
  a_r11_valid_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend & ~mask)) |-> msg_valid_o);
endmodule

// File: tb/test_irq_redirect_unit.sv
module test_irq_redirect_unit;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pins = '0;
  logic        valid, ready = 1'b0;
  logic [4:0]  pin_o;
  logic [7:0]  vec, dest;
  logic [2:0]  dlv;
  logic        dmode, pol, trig;

  always #4 clk = ~clk;

  irq_redirect_unit i_irq_redirect_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_pins_i(pins),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_pin_o(pin_o),
    .msg_vector_o(vec), .msg_deliv_o(dlv), .msg_dest_mode_o(dmode),
    .msg_polarity_o(pol), .msg_trigger_o(trig), .msg_dest_o(dest)
  );

  int checks = 0, failures = 0;
  string tag = "R1";

  // reference model
  logic [63:0] m_tbl [N];
  bit          m_pend [N];
  bit          m_prev [N];
  int          m_ptr;
  logic [7:0]  m_sel, m_id;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", req, tag, act, exp, $time);
    end
  endtask

  function automatic int m_pick();
    for (int k = 0; k < N; k++) begin
      int p = (m_ptr + k) % N;
      if (m_pend[p] && !m_tbl[p][16]) return p;
    end
    return -1;
  endfunction

  function automatic logic [31:0] m_win(input logic [7:0] s);
    if (s == 8'h00) return {m_id, 24'h0};
    if (s == 8'h01) return 32'h0017_0011;
    if (s >= 8'h10 && s <= 8'h3F) begin
      int t = (int'(s) - 16) / 2;
      return s[0] ? m_tbl[t][63:32] : m_tbl[t][31:0];
    end
    return 32'h0;
  endfunction

  function automatic string rd_req(input logic [7:0] a, input logic [7:0] s);
    if (a == 8'h00) return "R2";
    if (a != 8'h10) return "R2";
    if (s == 8'h00) return "R3";
    if (s == 8'h01) return "R4";
    if (s >= 8'h10 && s <= 8'h3F) return "R5";
    return "R6";
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_tbl[i] = 64'h0000_0000_0001_0000;
      m_pend[i] = 0;
      m_prev[i] = 0;
    end
    m_ptr = 0; m_sel = 0; m_id = 0;
  endtask

  task automatic compare();
    int p = m_pick();
    logic [31:0] er;
    chk(valid == (p >= 0), "R11 valid", valid, p >= 0);
    if (p >= 0 && valid) begin
      chk(int'(pin_o) == p, "R11 order", pin_o, p);
      chk({dest, vec, dlv, dmode, pol, trig} ==
          {m_tbl[p][63:56], m_tbl[p][7:0], m_tbl[p][10:8], m_tbl[p][11], m_tbl[p][13], m_tbl[p][15]},
          "R10 fields", {dest, vec, dlv, dmode, pol, trig},
          {m_tbl[p][63:56], m_tbl[p][7:0], m_tbl[p][10:8], m_tbl[p][11], m_tbl[p][13], m_tbl[p][15]});
    end
    er = (addr == 8'h00) ? {24'h0, m_sel} : (addr == 8'h10) ? m_win(m_sel) : 32'h0;
    chk(rdata == er, rd_req(addr, m_sel), rdata, er);
  endtask

  // advance model and DUT by one clock using the inputs now applied
  task automatic step();
    int p = m_pick();
    bit acc = (p >= 0) && ready;
    bit np [N];
    for (int i = 0; i < N; i++) begin
      bit rise = pins[i] && !m_prev[i];
      if (m_tbl[i][15]) np[i] = pins[i];
      else np[i] = (m_pend[i] && !(acc && p == i)) || rise;
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      m_pend[i] = np[i];
      m_prev[i] = pins[i];
    end
    if (acc) m_ptr = (p + 1) % N;
    if (wr && addr == 8'h00) m_sel = wdata[7:0];
    if (wr && addr == 8'h10) begin
      if (m_sel == 8'h00) m_id = wdata[31:24];
      else if (m_sel >= 8'h10 && m_sel <= 8'h3F) begin
        int t = (int'(m_sel) - 16) / 2;
        if (m_sel[0]) m_tbl[t][63:32] = wdata;
        else m_tbl[t][31:0] = wdata;
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
    reg_wr(8'h00, {24'h0, s});
    reg_wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] s);
    reg_wr(8'h00, {24'h0, s});
    addr = 8'h10;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    // R1: reset contents via every select, R4 and R6 reads
    tag = "R1";
    for (int s = 0; s < 72; s++) win_rd(8'(s));
    win_rd(8'hFF);
    // R2: other offsets read zero, writes ignored
    tag = "R2";
    reg_wr(8'h08, 32'hFFFF_FFFF);
    addr = 8'h20; step();
    addr = 8'h00; step();
    // R3
    tag = "R3";
    win_wr(8'h00, 32'hAB12_3456);
    win_rd(8'h00);
    // R4
    tag = "R4";
    win_wr(8'h01, 32'hFFFF_FFFF);
    win_rd(8'h01);
    // R6
    tag = "R6";
    win_wr(8'h05, 32'h1234_5678);
    win_wr(8'h40, 32'h0);
    win_wr(8'hFF, 32'h0);
    win_rd(8'h05); win_rd(8'h40); win_rd(8'h10);
    // R5: program entry 3, then rewrite only the low half
    tag = "R5";
    win_wr(8'h17, 32'h5A00_0000);
    win_wr(8'h16, 32'h0000_2923);
    win_wr(8'h16, 32'h0001_A123);
    win_rd(8'h17); win_rd(8'h16);
    win_wr(8'h16, 32'h0000_0923);
    // R8/R12: edge pulse held while ready low
    tag = "R8";
    ready = 1'b0;
    pins[3] = 1'b1; step();
    pins[3] = 1'b0; step(); step(); step();
    tag = "R12"; step(); step();
    tag = "R8";
    ready = 1'b1; step(); step();
    // R7: level line 7
    tag = "R7";
    win_wr(8'h1E, 32'h0000_A040);
    win_wr(8'h1F, 32'h0700_0000);
    pins[7] = 1'b1; step(); step(); step(); step();
    pins[7] = 1'b0; step(); step();
    // R9: masked edge kept, offered after unmask
    tag = "R9";
    win_wr(8'h16, 32'h0001_0923);
    pins[3] = 1'b1; step(); pins[3] = 1'b0; step(); step();
    win_wr(8'h16, 32'h0000_0923);
    step(); step();
    // R11: several rises at once, order and wrap
    tag = "R11";
    for (int i = 0; i < N; i++) win_wr(8'(16 + 2 * i), {16'h0, 8'h00, 8'(i + 8'h30)});
    pins = 24'hC0_0105; step(); pins = '0;
    repeat (8) step();
    pins[7] = 1'b1; win_wr(8'h1E, 32'h0000_8037);
    pins[22] = 1'b1; step(); pins[22] = 1'b0;
    repeat (6) step();
    pins = '0;
    // mixed random traffic
    tag = "R10";
    for (int c = 0; c < 4000; c++) begin
      ready = ($urandom % 4) != 0;
      pins = pins ^ (24'($urandom) & 24'($urandom) & 24'($urandom));
      if ($urandom % 6 == 0) begin
        wr = 1'b1;
        if ($urandom % 2 == 0) begin addr = 8'h00; wdata = 32'($urandom % 80); end
        else begin addr = 8'h10; wdata = $urandom & 32'hFF01_FFFF; end
      end else begin
        wr = 1'b0; addr = ($urandom % 2 == 0) ? 8'h10 : 8'h00;
      end
      step();
    end
    wr = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule